// File: doc/BRIEF.md
# Per-Page Random Line Rotation

This block remaps line addresses inside a page to spread write wear evenly across the lines of each page. It keeps one rotation amount per resident page frame. When a frame receives a page, on first fill or on replacement, a fresh pseudo-random rotation is drawn for it. That rotation then stays fixed for as long as the page remains in the frame.

Every line access to a frame is rewritten by adding the frame's rotation to the logical line index, modulo the number of lines per page. A page whose writes cluster on a few logical lines therefore lands those writes on different physical lines each time it is brought in. Over many residencies, write traffic per physical line evens out.

The lookup is a stream that is always accepted. `lkp_ready` is held high, so a request is never back-pressured, and the result appears in the same cycle with `res_valid` following `lkp_valid`. The allocate strobe is a plain control pin. The policy that chooses frames and the memory array itself sit outside this block.

Top module: `line_rotate_remap`

## Requirements
- R1: After reset every frame holds rotation 0, so any lookup returns a physical line equal to its logical line until that frame is allocated.
- R2: A lookup returns `res_line = (lkp_line + rot[lkp_frame]) mod 16` combinationally in the same cycle. `res_valid` equals `lkp_valid`, and `lkp_ready` is always 1.
- R3: An allocate strobe loads the addressed frame with bits [3:0] of the random generator's state in that cycle.
  - The generator is a 16-bit register that holds 0xACE1 during and right after reset.
  - On every clock edge with reset released it shifts left by one.
  - Its new bit 0 is the XOR of old bits 15, 13, 12 and 10.
- R4: A frame's rotation does not change in any cycle without an allocate to that frame. Allocates to other frames leave it untouched.
- R5: When an allocate and a lookup target the same frame in the same cycle, the lookup returns the old mapping. The new rotation applies from the next cycle.
- R6: For every rotation value 0 to 15, the 16 logical lines of a frame map to 16 distinct physical lines.
- R7: The random generator never reaches the all-zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Frame receives a new page this cycle |
| alloc_frame | input | 3 | Frame being (re)filled |
| lkp_valid | input | 1 | Lookup request valid |
| lkp_ready | output | 1 | Lookup accepted (always 1) |
| lkp_frame | input | 3 | Frame of the accessed page |
| lkp_line | input | 4 | Logical line within the page |
| res_valid | output | 1 | Lookup result valid |
| res_line | output | 4 | Physical line within the page |

## Verification
A corrupted rotation entry shows up on the very next lookup to that frame as a physical line that is offset from the expected one. A bench that compares every lookup each cycle therefore catches it within one access. A generator that steps wrongly stays hidden until the next allocate, which then loads an unexpected rotation; the lookups after that allocate expose it. A missing modular wrap shows as a lost or duplicated physical line when a frame is swept across all 16 logical lines.

// File: rtl/rot_pkg.sv
package rot_pkg;
  localparam int DEF_FRAMES = 8;
  localparam int DEF_LINES  = 16;
  localparam int DEF_RND_W  = 16;
  localparam logic [15:0] DEF_SEED = 16'hACE1;
  localparam logic [15:0] DEF_TAPS = 16'hB400;

  function automatic bit is_pow2(input int n);
    return (n > 0) && ((n & (n - 1)) == 0);
  endfunction
endpackage

// File: rtl/rot_lfsr.sv
module rot_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] SEED = '1,
  parameter logic [W-1:0] TAPS = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state_q
);
  logic fb;

  always_comb fb = ^(state_q & TAPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= {state_q[W-2:0], fb};
  end
endmodule

// File: rtl/rot_shift_table.sv
module rot_shift_table #(
  parameter int FRAMES  = 8,
  parameter int LINE_W  = 4,
  localparam int FRAME_W = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [FRAME_W-1:0]             wr_frame,
  input  logic [LINE_W-1:0]              wr_shift,
  output logic [FRAMES-1:0][LINE_W-1:0]  shift_q
);
  for (genvar f = 0; f < FRAMES; f++) begin : g_frame
    logic hit;
    always_comb hit = wr_en && (wr_frame == FRAME_W'(f));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   shift_q[f] <= '0;
      else if (hit) shift_q[f] <= wr_shift;
    end
  end
endmodule

// File: rtl/rot_line_adder.sv
module rot_line_adder #(
  parameter int LINES  = 16,
  parameter int LINE_W = 4
) (
  input  logic [LINE_W-1:0] a,
  input  logic [LINE_W-1:0] b,
  output logic [LINE_W-1:0] y
);
  if (rot_pkg::is_pow2(LINES)) begin : g_wrap
    always_comb y = a + b;
  end else begin : g_sub
    localparam logic [LINE_W:0] LIM = (LINE_W+1)'(LINES);
    logic [LINE_W:0] sum;
    always_comb begin
      sum = {1'b0, a} + {1'b0, b};
      if (sum >= LIM) sum = sum - LIM;
      y = sum[LINE_W-1:0];
    end
  end
endmodule

// File: rtl/line_rotate_remap.sv
module line_rotate_remap #(
  parameter int          FRAMES = rot_pkg::DEF_FRAMES,
  parameter int          LINES  = rot_pkg::DEF_LINES,
  parameter int          RND_W  = rot_pkg::DEF_RND_W,
  parameter logic [15:0] SEED   = rot_pkg::DEF_SEED,
  parameter logic [15:0] TAPS   = rot_pkg::DEF_TAPS,
  localparam int FRAME_W = (FRAMES > 1) ? $clog2(FRAMES) : 1,
  localparam int LINE_W  = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_valid,
  input  logic [FRAME_W-1:0] alloc_frame,
  input  logic               lkp_valid,
  output logic               lkp_ready,
  input  logic [FRAME_W-1:0] lkp_frame,
  input  logic [LINE_W-1:0]  lkp_line,
  output logic               res_valid,
  output logic [LINE_W-1:0]  res_line
);
  logic [RND_W-1:0]                lfsr_q;
  logic [FRAMES-1:0][LINE_W-1:0]   shift_q;
  logic [LINE_W-1:0]               draw;
  logic [LINE_W-1:0]               sel_shift;
  logic [LINE_W:0]                 draw_wide;

  rot_lfsr #(.W(RND_W), .SEED(RND_W'(SEED)), .TAPS(RND_W'(TAPS))) u_rnd (
    .clk(clk), .rst_n(rst_n), .state_q(lfsr_q)
  );

  // Fold the raw draw into range when LINES is not a power of two.
  always_comb begin
    draw_wide = {1'b0, lfsr_q[LINE_W-1:0]};
    if (draw_wide >= (LINE_W+1)'(LINES)) draw_wide = draw_wide - (LINE_W+1)'(LINES);
    draw = draw_wide[LINE_W-1:0];
  end

  rot_shift_table #(.FRAMES(FRAMES), .LINE_W(LINE_W)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(alloc_valid), .wr_frame(alloc_frame), .wr_shift(draw),
    .shift_q(shift_q)
  );

  always_comb sel_shift = shift_q[lkp_frame];

  rot_line_adder #(.LINES(LINES), .LINE_W(LINE_W)) u_add (
    .a(lkp_line), .b(sel_shift), .y(res_line)
  );

  assign lkp_ready = 1'b1;
  assign res_valid = lkp_valid;
endmodule

// File: rtl/line_rotate_chk.sv
module line_rotate_chk #(
  parameter int FRAMES = 8,
  parameter int LINES  = 16,
  parameter int RND_W  = 16,
  localparam int FRAME_W = (FRAMES > 1) ? $clog2(FRAMES) : 1,
  localparam int LINE_W  = (LINES > 1) ? $clog2(LINES) : 1
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          alloc_valid,
  input logic [FRAME_W-1:0]            alloc_frame,
  input logic                          lkp_valid,
  input logic                          lkp_ready,
  input logic [FRAME_W-1:0]            lkp_frame,
  input logic [LINE_W-1:0]             lkp_line,
  input logic                          res_valid,
  input logic [LINE_W-1:0]             res_line,
  input logic [RND_W-1:0]              lfsr_q,
  input logic [FRAMES-1:0][LINE_W-1:0] shift_q
);
  a_r1_reset_zero: assert property (@(posedge clk) $rose(rst_n) |-> (shift_q == '0));

  a_r2_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_ready && (res_valid == lkp_valid));

  a_r2_mapping: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_valid |-> (32'(res_line) == (32'(lkp_line) + 32'(shift_q[lkp_frame])) % LINES));

  a_r3_draw_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |=> (32'(shift_q[$past(alloc_frame)]) == 32'($past(lfsr_q[LINE_W-1:0])) % LINES));

  for (genvar f = 0; f < FRAMES; f++) begin : g_stab
    a_r4_shift_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !(alloc_valid && alloc_frame == FRAME_W'(f)) |=> $stable(shift_q[f]));
  end

  a_r7_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n) lfsr_q != '0);
endmodule

bind line_rotate_remap line_rotate_chk #(.FRAMES(FRAMES), .LINES(LINES), .RND_W(RND_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_frame(alloc_frame),
  .lkp_valid(lkp_valid), .lkp_ready(lkp_ready), .lkp_frame(lkp_frame), .lkp_line(lkp_line),
  .res_valid(res_valid), .res_line(res_line), .lfsr_q(lfsr_q), .shift_q(shift_q)
);

// File: tb/line_rotate_remap_tb.sv
`timescale 1ns/1ps
module line_rotate_remap_tb;
  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0, lkp_valid = 0;
  logic [2:0] alloc_frame = 0, lkp_frame = 0;
  logic [3:0] lkp_line = 0;
  logic lkp_ready, res_valid;
  logic [3:0] res_line;

  int checks = 0, errors = 0;
  int m_lfsr;
  int m_shift [8];
  int seen_shifts = 0;

  always #2.5 clk = ~clk;

  line_rotate_remap u_dut (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_frame(alloc_frame),
    .lkp_valid(lkp_valid), .lkp_ready(lkp_ready), .lkp_frame(lkp_frame), .lkp_line(lkp_line),
    .res_valid(res_valid), .res_line(res_line)
  );

  // Behavioural reference: generator and rotation per frame (R3, R4)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lfsr = 16'hACE1;
      foreach (m_shift[i]) m_shift[i] = 0;
    end else begin
      if (alloc_valid) begin
        m_shift[alloc_frame] = m_lfsr & 15;
        seen_shifts = seen_shifts | (1 << (m_lfsr & 15));
      end
      m_lfsr = ((m_lfsr << 1) & 16'hFFFE) |
               (((m_lfsr >> 15) ^ (m_lfsr >> 13) ^ (m_lfsr >> 12) ^ (m_lfsr >> 10)) & 1);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare combinational result before the edge.
  task automatic step(input bit a, input int af, input bit v, input int lf, input int ll,
                      input string req);
    @(negedge clk);
    alloc_valid = a; alloc_frame = 3'(af);
    lkp_valid = v; lkp_frame = 3'(lf); lkp_line = 4'(ll);
    #1;
    chk("R2 ready", int'(lkp_ready), 1);
    chk("R2 res_valid", int'(res_valid), int'(v));
    if (v) chk(req, int'(res_line), (ll + m_shift[lf]) % 16);
  endtask

  initial begin
    int held;
    int mask;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: every frame maps identity after reset
    for (int f = 0; f < 8; f++)
      for (int l = 0; l < 16; l += 5) begin
        step(0, 0, 1, f, l, "R1 reset identity");
        chk("R1 identity", int'(res_line), l);
      end
    // R5: same-cycle allocate and lookup of one frame uses the old mapping
    step(1, 2, 1, 2, 7, "R5 old mapping");
    chk("R5 old mapping", int'(res_line), 7);
    step(0, 0, 1, 2, 7, "R5 new mapping next cycle");
    // R4: allocations elsewhere leave frame 2 alone
    held = m_shift[2];
    for (int i = 0; i < 24; i++) step(1, (i % 7 == 2) ? 3 : i % 7, 1, 2, 0, "R4 other frames");
    step(0, 0, 1, 2, 0, "R4 held");
    chk("R4 shift held", int'(res_line), held);
    // R3, R6: repeated redraws, sweep each frame for a bijection
    for (int r = 0; r < 160; r++) begin
      int fr = r % 8;
      step(1, fr, 0, 0, 0, "R3 alloc");
      repeat (r % 3) step(0, 0, 0, 0, 0, "R3 idle");
      mask = 0;
      for (int l = 0; l < 16; l++) begin
        step(0, 0, 1, fr, l, "R3 drawn rotation");
        mask = mask | (1 << int'(res_line));
      end
      chk("R6 bijection", mask, 16'hFFFF);
    end
    chk("R6 all rotation values exercised", seen_shifts, 16'hFFFF);
    // R1: reset again clears rotations
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    for (int f = 0; f < 8; f++) begin
      step(0, 0, 1, f, 9, "R1 after re-reset");
      chk("R1 re-reset identity", int'(res_line), 9);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule